// File: doc/BRIEF.md
# Codec Register Mailbox

This block carries register commands from a host processor to an external audio codec and brings register contents back. It has two one-entry buffers. The command buffer holds one 32-bit word: a read/write flag, a 7-bit register index and 16 bits of data. The serial link engine takes that word at the next frame boundary. The status buffer holds the last register value the codec returned, and the host collects it from there. Each buffer drives its own interrupt, and the host must enable each interrupt before it uses it.

A host writes a series of codec registers one at a time. It loads a command and waits for the "command sent" interrupt, then loads the next command. A register read works the same way. The host issues a read command and waits for the "status ready" interrupt. The status buffer accepts only a returned slot whose register index matches the outstanding read.

The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock.

Top module: `codec_reg_mailbox`

## Requirements
- R1: After reset both buffers are empty. All flags, interrupt enables, interrupts and stored words are zero.
- R2: A host command write while the command buffer is empty stores the word, and `link_cmd_valid` rises on the next cycle. The link engine decodes the word as follows: bit 23 is the read flag, bits 22:16 are the register index and bits 15:0 are the write data.
- R3: A host command write while the command buffer is full is ignored. The stored word is unchanged and `wr_err` is set. `wr_err` stays set until the next accepted write clears it.
- R4: `link_take` while the command buffer is full empties the buffer on the next cycle. `link_take` while the buffer is empty has no effect.
- R5: A take sets a sticky "sent" event, and the next accepted host write clears it. `irq_wempty` is that event ANDed with enable bit 0.
- R6: When a read command (bit 23 set) is taken, its index becomes the outstanding read. A later return with that index loads the status buffer as {9'b0, index[6:0], data[15:0]}, sets `rbuf_full` and retires the outstanding read.
- R7: A return whose index does not match, or any return while no read is outstanding, leaves the status buffer unchanged.
- R8: `host_rd_status` clears `rbuf_full` and `rbuf_ovf` on the next cycle. `host_rdata` keeps the last word.
- R9: A matching return while the status buffer is full overwrites the word and sets `rbuf_ovf`. If the host reads in that same cycle, the new word stays full and `rbuf_ovf` stays clear.
- R10: `irq_rfull` is `rbuf_full` ANDed with enable bit 1.
- R11: `ien_we` loads the two enable bits from `ien_wdata` on the next cycle. Bit 0 enables the sent interrupt and bit 1 enables the status-ready interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_cmd | input | 1 | Host writes the command buffer |
| host_wdata | input | 32 | Command word from host |
| host_rd_status | input | 1 | Host reads (pops) the status buffer |
| host_rdata | output | 32 | Status buffer contents |
| ien_we | input | 1 | Load interrupt enables |
| ien_wdata | input | 2 | Enable bits: 0 = sent, 1 = status ready |
| wr_err | output | 1 | Command write was rejected |
| rbuf_full | output | 1 | Status buffer holds unread data |
| rbuf_ovf | output | 1 | Unread status was overwritten |
| irq_wempty | output | 1 | Command-sent interrupt |
| irq_rfull | output | 1 | Status-ready interrupt |
| link_cmd_valid | output | 1 | Command buffer full |
| link_cmd_word | output | 32 | Pending command word |
| link_take | input | 1 | Link engine consumes the command this frame |
| link_ret_valid | input | 1 | A returned register slot is present |
| link_ret_idx | input | 7 | Index carried by the returned slot |
| link_ret_data | input | 16 | Data carried by the returned slot |

## Verification
The assertions assume that the link engine's strobes are single-cycle pulses sampled on the clock. They also assume that a host read and a link return in the same cycle are allowed, and that the "read clears" property holds only in cycles with no return. The stimulus drives every input on the falling edge. Returned indices are drawn partly from the outstanding read index and partly from four fixed codec registers, so both matching and mismatching returns occur often. This also makes overwrite-while-full and write-while-full collisions common, without any input ever going to X.

// File: rtl/codec_mbox_pkg.sv
package codec_mbox_pkg;
  parameter int WORD_W = 32;
  parameter int IDX_W  = 7;
  parameter int DAT_W  = 16;
  parameter int RD_BIT = DAT_W + IDX_W;
  localparam int IDX_LO = DAT_W;
  localparam int IDX_HI = DAT_W + IDX_W - 1;
  localparam int N_IRQ  = 2;
  localparam int IRQ_SENT  = 0;
  localparam int IRQ_READY = 1;
endpackage

// File: rtl/mbox_cmd_buf.sv
module mbox_cmd_buf
  import codec_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              link_take,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              err,
  output logic              sent_ev,
  output logic              take_rd,
  output logic [IDX_W-1:0]  take_idx
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              err_q, err_d;
  logic              sent_q, sent_d;
  logic              accept, take;

  assign accept = host_wr & ~full_q;
  assign take   = link_take & full_q;

  always_comb begin
    full_d = full_q;
    word_d = word_q;
    err_d  = err_q;
    sent_d = sent_q;
    if (take) begin
      full_d = 1'b0;
      sent_d = 1'b1;
    end
    if (accept) begin
      full_d = 1'b1;
      word_d = host_wdata;
      err_d  = 1'b0;
      sent_d = 1'b0;
    end else if (host_wr) begin
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      err_q  <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      full_q <= full_d;
      word_q <= word_d;
      err_q  <= err_d;
      sent_q <= sent_d;
    end
  end

  assign full     = full_q;
  assign word     = word_q;
  assign err      = err_q;
  assign sent_ev  = sent_q;
  assign take_rd  = take & word_q[RD_BIT];
  assign take_idx = word_q[IDX_HI:IDX_LO];
endmodule

// File: rtl/mbox_sts_buf.sv
module mbox_sts_buf
  import codec_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_rd,
  input  logic [IDX_W-1:0]  take_idx,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_idx,
  input  logic [DAT_W-1:0]  ret_data,
  input  logic              host_rd,
  output logic              full,
  output logic              ovf,
  output logic [WORD_W-1:0] word
);
  logic              pend_q, pend_d;
  logic [IDX_W-1:0]  pidx_q, pidx_d;
  logic              full_q, full_d;
  logic              ovf_q, ovf_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              match;

  assign match = ret_valid & pend_q & (ret_idx == pidx_q);

  always_comb begin
    pend_d = pend_q;
    pidx_d = pidx_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    word_d = word_q;
    if (take_rd) begin
      pend_d = 1'b1;
      pidx_d = take_idx;
    end else if (match) begin
      pend_d = 1'b0;
    end
    if (match) begin
      word_d = '0;
      word_d[IDX_HI:IDX_LO] = ret_idx;
      word_d[DAT_W-1:0]     = ret_data;
      full_d = 1'b1;
      ovf_d  = full_q & ~host_rd;
    end else if (host_rd) begin
      full_d = 1'b0;
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= pend_d;
      pidx_q <= pidx_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      word_q <= word_d;
    end
  end

  assign full = full_q;
  assign ovf  = ovf_q;
  assign word = word_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import codec_mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [N_IRQ-1:0] en_wdata,
  input  logic [N_IRQ-1:0] src,
  output logic [N_IRQ-1:0] irq
);
  logic [N_IRQ-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_gate
    assign irq[i] = src[i] & en_q[i];
  end
endmodule

// File: rtl/codec_reg_mailbox.sv
module codec_reg_mailbox
  import codec_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_cmd,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd_status,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              ien_we,
  input  logic [N_IRQ-1:0]  ien_wdata,
  output logic              wr_err,
  output logic              rbuf_full,
  output logic              rbuf_ovf,
  output logic              irq_wempty,
  output logic              irq_rfull,
  output logic              link_cmd_valid,
  output logic [WORD_W-1:0] link_cmd_word,
  input  logic              link_take,
  input  logic              link_ret_valid,
  input  logic [IDX_W-1:0]  link_ret_idx,
  input  logic [DAT_W-1:0]  link_ret_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             sent_ev, take_rd;
  logic [IDX_W-1:0] take_idx;
  logic [N_IRQ-1:0] irq_src, irq_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mbox_cmd_buf u_cmd (
    .clk(clk), .rst_n(rst_int_n),
    .host_wr(host_wr_cmd), .host_wdata(host_wdata), .link_take(link_take),
    .full(link_cmd_valid), .word(link_cmd_word), .err(wr_err),
    .sent_ev(sent_ev), .take_rd(take_rd), .take_idx(take_idx)
  );

  mbox_sts_buf u_sts (
    .clk(clk), .rst_n(rst_int_n),
    .take_rd(take_rd), .take_idx(take_idx),
    .ret_valid(link_ret_valid), .ret_idx(link_ret_idx), .ret_data(link_ret_data),
    .host_rd(host_rd_status),
    .full(rbuf_full), .ovf(rbuf_ovf), .word(host_rdata)
  );

  assign irq_src[IRQ_SENT]  = sent_ev;
  assign irq_src[IRQ_READY] = rbuf_full;

  mbox_irq u_irq (
    .clk(clk), .rst_n(rst_int_n),
    .en_we(ien_we), .en_wdata(ien_wdata), .src(irq_src), .irq(irq_vec)
  );

  assign irq_wempty = irq_vec[IRQ_SENT];
  assign irq_rfull  = irq_vec[IRQ_READY];
endmodule

// File: rtl/codec_reg_mailbox_chk.sv
module codec_reg_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr_cmd,
  input logic        host_rd_status,
  input logic        link_take,
  input logic        link_ret_valid,
  input logic        link_cmd_valid,
  input logic [31:0] link_cmd_word,
  input logic        wr_err,
  input logic        rbuf_full,
  input logic        rbuf_ovf,
  input logic        irq_wempty,
  input logic        irq_rfull
);
  p_take_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_cmd_valid && link_take |=> !link_cmd_valid);

  p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_cmd_valid && host_wr_cmd && !link_take |=>
      wr_err && link_cmd_valid && $stable(link_cmd_word));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_full && host_rd_status && !link_ret_valid |=> !rbuf_full && !rbuf_ovf);

  p_ovf_only_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_ovf |-> rbuf_full);

  p_ready_irq_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rfull |-> rbuf_full);

  p_sent_irq_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wempty |-> !link_cmd_valid);
endmodule

bind codec_reg_mailbox codec_reg_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_wr_cmd(host_wr_cmd), .host_rd_status(host_rd_status),
  .link_take(link_take), .link_ret_valid(link_ret_valid),
  .link_cmd_valid(link_cmd_valid), .link_cmd_word(link_cmd_word),
  .wr_err(wr_err), .rbuf_full(rbuf_full), .rbuf_ovf(rbuf_ovf),
  .irq_wempty(irq_wempty), .irq_rfull(irq_rfull)
);

// File: tb/codec_reg_mailbox_test.sv
module codec_reg_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_cmd, host_rd_status, ien_we, link_take, link_ret_valid;
  logic [31:0] host_wdata;
  logic [1:0]  ien_wdata;
  logic [6:0]  link_ret_idx;
  logic [15:0] link_ret_data;
  logic [31:0] host_rdata, link_cmd_word;
  logic        wr_err, rbuf_full, rbuf_ovf, irq_wempty, irq_rfull, link_cmd_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  codec_reg_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
    .host_rd_status(host_rd_status), .host_rdata(host_rdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .wr_err(wr_err), .rbuf_full(rbuf_full), .rbuf_ovf(rbuf_ovf),
    .irq_wempty(irq_wempty), .irq_rfull(irq_rfull),
    .link_cmd_valid(link_cmd_valid), .link_cmd_word(link_cmd_word),
    .link_take(link_take), .link_ret_valid(link_ret_valid),
    .link_ret_idx(link_ret_idx), .link_ret_data(link_ret_data)
  );

  // reference model state, derived from the requirements
  logic        m_wfull, m_err, m_sent, m_pend, m_rfull, m_ovf;
  logic [31:0] m_wword, m_rword;
  logic [6:0]  m_pidx;
  logic [1:0]  m_ien;

  function automatic logic [31:0] sts_word(input logic [6:0] idx, input logic [15:0] d);
    return {9'b0, idx, d};
  endfunction

  function automatic logic [31:0] cmd_word(input logic rd, input logic [6:0] idx,
                                           input logic [15:0] d);
    return {8'h00, rd, idx, d};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wfull = 0; m_err = 0; m_sent = 0; m_pend = 0; m_rfull = 0; m_ovf = 0;
      m_wword = 0; m_rword = 0; m_pidx = 0; m_ien = 0;
    end else begin
      logic acc, tk, mt;
      acc = host_wr_cmd && !m_wfull;
      tk  = link_take && m_wfull;
      mt  = link_ret_valid && m_pend && (link_ret_idx == m_pidx);
      if (mt) begin
        m_rword = sts_word(link_ret_idx, link_ret_data);
        m_ovf   = m_rfull && !host_rd_status;
        m_rfull = 1;
      end else if (host_rd_status) begin
        m_rfull = 0; m_ovf = 0;
      end
      if (tk && m_wword[23]) begin m_pend = 1; m_pidx = m_wword[22:16]; end
      else if (mt) m_pend = 0;
      if (tk) begin m_wfull = 0; m_sent = 1; end
      if (acc) begin m_wfull = 1; m_wword = host_wdata; m_err = 0; m_sent = 0; end
      else if (host_wr_cmd) m_err = 1;
      if (ien_we) m_ien = ien_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2/R4 link_cmd_valid", {31'b0, link_cmd_valid}, {31'b0, m_wfull});
    check("R2 link_cmd_word", link_cmd_word, m_wword);
    check("R3 wr_err", {31'b0, wr_err}, {31'b0, m_err});
    check("R6 host_rdata", host_rdata, m_rword);
    check("R8 rbuf_full", {31'b0, rbuf_full}, {31'b0, m_rfull});
    check("R9 rbuf_ovf", {31'b0, rbuf_ovf}, {31'b0, m_ovf});
    check("R5 irq_wempty", {31'b0, irq_wempty}, {31'b0, m_sent & m_ien[0]});
    check("R10 irq_rfull", {31'b0, irq_rfull}, {31'b0, m_rfull & m_ien[1]});
  endtask

  task automatic idle_in();
    host_wr_cmd = 0; host_wdata = 0; host_rd_status = 0; ien_we = 0; ien_wdata = 0;
    link_take = 0; link_ret_valid = 0; link_ret_idx = 0; link_ret_data = 0;
  endtask

  // one cycle: check outputs at the falling edge, then drive the next inputs
  task automatic cyc(input logic hw, input logic [31:0] wd, input logic hr,
                     input logic tk, input logic rv, input logic [6:0] ri,
                     input logic [15:0] rdat, input logic ie, input logic [1:0] iw);
    @(negedge clk);
    check_all();
    host_wr_cmd = hw; host_wdata = wd; host_rd_status = hr; link_take = tk;
    link_ret_valid = rv; link_ret_idx = ri; link_ret_data = rdat;
    ien_we = ie; ien_wdata = iw;
  endtask

  task automatic nop();
    cyc(0, 32'h0, 0, 0, 0, 7'h0, 16'h0, 0, 2'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [6:0] regs [4];
    regs[0] = 7'h02; regs[1] = 7'h18; regs[2] = 7'h2A; regs[3] = 7'h2C;
    void'($urandom(32'd1234));
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 link_cmd_valid", {31'b0, link_cmd_valid}, 32'd0);
    check("R1 host_rdata", host_rdata, 32'd0);
    check("R1 flags", {27'b0, wr_err, rbuf_full, rbuf_ovf, irq_wempty, irq_rfull}, 32'd0);
    rst_n = 1;
    repeat (4) nop();

    // R11: enable both interrupts
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'b11);
    // paced write sequence of four registers (R2, R4, R5)
    for (int i = 0; i < 4; i++) begin
      cyc(1, cmd_word(0, regs[i], 16'(i * 16'h1111)), 0, 0, 0, 0, 0, 0, 0);
      nop();
      check("R2 valid after write", {31'b0, link_cmd_valid}, 32'd1);
      check("R5 irq low while pending", {31'b0, irq_wempty}, 32'd0);
      // R3: second write while full is ignored
      cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      nop();
      check("R4 empty after take", {31'b0, link_cmd_valid}, 32'd0);
      check("R5 irq after take", {31'b0, irq_wempty}, 32'd1);
      check("R3 error flagged", {31'b0, wr_err}, 32'd1);
    end
    // R4: take while empty has no effect
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    nop();
    check("R4 take when empty", {31'b0, link_cmd_valid}, 32'd0);

    // read of register 26h (R6, R7, R8)
    cyc(1, cmd_word(1, 7'h26, 16'h0), 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 7'h18, 16'hBEEF, 0, 0);
    nop();
    check("R7 mismatched return ignored", {31'b0, rbuf_full}, 32'd0);
    cyc(0, 0, 0, 0, 1, 7'h26, 16'h000F, 0, 0);
    nop();
    check("R6 status latched", host_rdata, sts_word(7'h26, 16'h000F));
    check("R10 ready irq", {31'b0, irq_rfull}, 32'd1);
    cyc(0, 0, 0, 0, 1, 7'h26, 16'h1234, 0, 0);
    nop();
    check("R7 retired read ignored", host_rdata, sts_word(7'h26, 16'h000F));
    // R9: second read returns while still full
    cyc(1, cmd_word(1, 7'h2C, 16'h0), 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 7'h2C, 16'h5622, 0, 0);
    nop();
    check("R9 overflow set", {31'b0, rbuf_ovf}, 32'd1);
    check("R9 word overwritten", host_rdata, sts_word(7'h2C, 16'h5622));
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    nop();
    check("R8 read clears full", {30'b0, rbuf_full, rbuf_ovf}, 32'd0);
    // R11: disable ready irq, fill again
    cyc(1, cmd_word(1, 7'h02, 16'h0), 0, 0, 0, 0, 0, 1, 2'b01);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 7'h02, 16'h8000, 0, 0);
    nop();
    check("R11 ready irq masked", {30'b0, rbuf_full, irq_rfull}, 32'd2);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] ri;
      logic [31:0] wd;
      wd = cmd_word(1'($urandom), regs[$urandom % 4], 16'($urandom));
      ri = ($urandom % 2 == 0) ? m_pidx : regs[$urandom % 4];
      cyc(($urandom % 3) == 0, wd, ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 3) == 0, ri, 16'($urandom),
          ($urandom % 10) == 0, 2'($urandom));
    end
    nop();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule